// File: doc/BRIEF.md
# Masked Sliding-Window Layer Coincidence Trigger

This block forms a detector trigger from 112 discriminated hit lines. The lines cover two views (X and Y). Each view has 14 layers, and each layer carries four fold levels. For every view and fold level, the block looks for a run of neighbouring layers that are all hit. The run length depends on the fold level: the one-fold lines need the longest run and the four-fold lines need the shortest. Each of the eight view/fold results is a registered output. Their OR forms the logic trigger.

A small register-write port loads fourteen 8-bit mask words and a 3-bit pulse-width code. A set mask bit removes its channel from the search. A rising edge of the logic trigger starts an output pulse. The pulse lasts a whole number of 50 ns units, quantised to the clock period. The hit lines are treated as asynchronous, so each one passes through a two-flop synchroniser first.

Top module: `layer_coinc_trigger`

## Requirements
- R1: View/fold output bit `4*v+f` (v=0 for X, v=1 for Y; f=0..3 for one- to four-fold) is high when the `5-f` consecutive layers `s..s+4-f` are all hit, for some start layer s. Fewer adjacent hits leave it low.
- R2: Channel index `56*v + 14*f + (layer-1)` on `hits_i` feeds only view v. A pattern confined to one view never raises a bit of the other view.
- R3: `logic_trig_o` is the OR of the eight view/fold outputs, one cycle later. If all eight are low, it is low on the next cycle.
- R4: A channel whose mask bit is 1 counts as not hit. Every window containing that layer is therefore blocked, and windows that avoid it still fire.
- R5: Mask word k (write address k, 0..13) bit b controls channel `8*k+b`, using the channel index from R2.
- R6: After reset, every mask bit and the width code are 0, and all outputs are low.
- R7: A write takes effect only when its function code is 17. Writes with any other function code change neither the masks nor the width code, and function-17 writes to address 14 change nothing.
- R8: A function-17 write to address 15 sets the width code from data bits [2:0]. The pulse lasts `max(code,1) * (50 / CLK_NS)` cycles, which is 6, 6, 18 and 42 cycles for codes 0, 1, 3 and 7 at CLK_NS=8.
- R9: A hit first sampled at clock edge E0 shows on the view/fold outputs after edge E2, and on `logic_trig_o` and `pulse_o` after edge E3.
- R10: The pulse count restarts only on a new rising edge of the logic trigger. A trigger held high gives a single pulse of the programmed width, while a fresh rising edge during a pulse reloads the full width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hits_i | input | 112 | Discriminated hit lines, indexed as in R2 |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Write address (0..13 mask words, 15 width code) |
| wr_func_i | input | 5 | Write function code; only 17 writes |
| wr_data_i | input | 8 | Write data |
| view_trig_o | output | 8 | Registered view/fold coincidence results |
| logic_trig_o | output | 1 | Registered OR of all view/fold results |
| pulse_o | output | 1 | Stretched trigger pulse |

## Verification
Some properties are checked on every cycle by assertions. A quiet masked input gives quiet view/fold outputs on the next cycle. No view/fold activity means no logic trigger. A pulse only begins together with a rising logic trigger. Masks read zero after reset, and writes with a foreign function code leave the masks and the width code unchanged. Other behaviour can only be shown by the bench scenarios, because it depends on sequences of stimulus. These are the exact window lengths at their boundaries, how mask bits are packed into words, blocking by a masked layer, pulse lengths for each width code, the pipeline latency, and the difference between a held trigger and a retriggered one.

// File: rtl/lct_pkg.sv
package lct_pkg;
  localparam int ADDR_W     = 4;
  localparam int FUNC_W     = 5;
  localparam int NUM_VIEWS  = 2;
  localparam logic [FUNC_W-1:0] WRITE_FUNC = 5'd17;
  localparam logic [ADDR_W-1:0] WIDTH_SLOT = 4'd15;
endpackage

// File: rtl/lct_cfg_regs.sv
module lct_cfg_regs
  import lct_pkg::*;
#(
  parameter int NUM_CH = 112,
  parameter int WORD_W = 8,
  parameter int CODE_W = 3,
  localparam int NUM_WORDS = NUM_CH / WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [FUNC_W-1:0] wr_func_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [NUM_CH-1:0] mask_o,
  output logic [CODE_W-1:0] code_o
);
  logic [NUM_WORDS-1:0][WORD_W-1:0] words_q;
  logic [CODE_W-1:0]                code_q;
  logic                             wr_ok;

  assign wr_ok = wr_en_i && (wr_func_i == WRITE_FUNC);

  always_ff @(posedge clk) begin
    if (rst) begin
      words_q <= '0;
      code_q  <= '0;
    end else if (wr_ok) begin
      if (wr_addr_i < ADDR_W'(NUM_WORDS))
        words_q[wr_addr_i] <= wr_data_i;
      else if (wr_addr_i == WIDTH_SLOT)
        code_q <= wr_data_i[CODE_W-1:0];
    end
  end

  assign mask_o = words_q;
  assign code_o = code_q;

  assert_mask_clear_after_reset_R6: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask_o == '0 && code_o == '0));

  assert_foreign_func_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && wr_func_i != WRITE_FUNC) |=> ($stable(mask_o) && $stable(code_o)));
endmodule

// File: rtl/lct_view_window.sv
module lct_view_window #(
  parameter int NUM_LAYERS = 14,
  parameter int NUM_FOLDS  = 4,
  parameter int BASE_WIN   = 5,
  localparam int VIEW_CH   = NUM_LAYERS * NUM_FOLDS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [VIEW_CH-1:0]   hits_i,
  output logic [NUM_FOLDS-1:0] det_o
);
  logic [NUM_FOLDS-1:0] det_d;
  logic [NUM_FOLDS-1:0] det_q;

  for (genvar f = 0; f < NUM_FOLDS; f++) begin : g_fold
    localparam int WIN  = BASE_WIN - f;
    localparam int NPOS = NUM_LAYERS - WIN + 1;
    logic [NPOS-1:0] win_hit;
    for (genvar s = 0; s < NPOS; s++) begin : g_pos
      assign win_hit[s] = &hits_i[f*NUM_LAYERS + s +: WIN];
    end
    assign det_d[f] = |win_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) det_q <= '0;
    else     det_q <= det_d;
  end

  assign det_o = det_q;

  assert_quiet_view_quiet_det_R1: assert property (@(posedge clk) disable iff (rst)
    !(|hits_i) |=> (det_o == '0));
endmodule

// File: rtl/lct_pulse_stretch.sv
module lct_pulse_stretch #(
  parameter int CODE_W = 3,
  parameter int STEP   = 6,
  localparam int MAX_LEN = ((1 << CODE_W) - 1) * STEP,
  localparam int CNT_W   = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              any_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              trig_o,
  output logic              pulse_o
);
  logic             trig_q;
  logic             pulse_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_len;
  logic [CNT_W-1:0] code_eff;
  logic             rise;

  assign code_eff = (code_i == '0) ? CNT_W'(1) : CNT_W'(code_i);
  assign load_len = code_eff * CNT_W'(STEP) - CNT_W'(1);
  assign rise     = any_i && !trig_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_q  <= 1'b0;
      pulse_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      trig_q <= any_i;
      if (rise) begin
        pulse_q <= 1'b1;
        cnt_q   <= load_len;
      end else if (cnt_q != '0) begin
        pulse_q <= 1'b1;
        cnt_q   <= cnt_q - CNT_W'(1);
      end else begin
        pulse_q <= 1'b0;
      end
    end
  end

  assign trig_o  = trig_q;
  assign pulse_o = pulse_q;

  assert_no_trig_without_views_R3: assert property (@(posedge clk) disable iff (rst)
    !any_i |=> !trig_o);

  assert_pulse_starts_on_edge_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_o) |-> $rose(trig_o));
endmodule

// File: rtl/layer_coinc_trigger.sv
module layer_coinc_trigger
  import lct_pkg::*;
#(
  parameter int NUM_LAYERS = 14,
  parameter int NUM_FOLDS  = 4,
  parameter int BASE_WIN   = 5,
  parameter int WORD_W     = 8,
  parameter int CODE_W     = 3,
  parameter int CLK_NS     = 8,
  parameter int UNIT_NS    = 50,
  localparam int VIEW_CH   = NUM_LAYERS * NUM_FOLDS,
  localparam int NUM_CH    = VIEW_CH * NUM_VIEWS,
  localparam int NUM_DET   = NUM_FOLDS * NUM_VIEWS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_CH-1:0]  hits_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [FUNC_W-1:0]  wr_func_i,
  input  logic [WORD_W-1:0]  wr_data_i,
  output logic [NUM_DET-1:0] view_trig_o,
  output logic               logic_trig_o,
  output logic               pulse_o
);
  localparam int STEP = (UNIT_NS / CLK_NS < 1) ? 1 : UNIT_NS / CLK_NS;

  logic [NUM_CH-1:0]  sync1_q;
  logic [NUM_CH-1:0]  sync2_q;
  logic [NUM_CH-1:0]  mask;
  logic [NUM_CH-1:0]  live;
  logic [CODE_W-1:0]  code;
  logic [NUM_DET-1:0] det;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= hits_i;
      sync2_q <= sync1_q;
    end
  end

  lct_cfg_regs #(.NUM_CH(NUM_CH), .WORD_W(WORD_W), .CODE_W(CODE_W)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_func_i (wr_func_i),
    .wr_data_i (wr_data_i),
    .mask_o    (mask),
    .code_o    (code)
  );

  assign live = sync2_q & ~mask;

  for (genvar v = 0; v < NUM_VIEWS; v++) begin : g_view
    lct_view_window #(
      .NUM_LAYERS (NUM_LAYERS),
      .NUM_FOLDS  (NUM_FOLDS),
      .BASE_WIN   (BASE_WIN)
    ) u_win (
      .clk    (clk),
      .rst    (rst),
      .hits_i (live[v*VIEW_CH +: VIEW_CH]),
      .det_o  (det[v*NUM_FOLDS +: NUM_FOLDS])
    );
  end

  lct_pulse_stretch #(.CODE_W(CODE_W), .STEP(STEP)) u_stretch (
    .clk     (clk),
    .rst     (rst),
    .any_i   (|det),
    .code_i  (code),
    .trig_o  (logic_trig_o),
    .pulse_o (pulse_o)
  );

  assign view_trig_o = det;

  assert_masked_input_blocks_R4: assert property (@(posedge clk) disable iff (rst)
    (live == '0) |=> (view_trig_o == '0));
endmodule

// File: tb/tb_layer_coinc_trigger.sv
module tb_layer_coinc_trigger;
  localparam int NL = 14;
  localparam int NF = 4;
  localparam int NCH = 112;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] hits = '0;
  logic           wr_en = 1'b0;
  logic [3:0]     wr_addr = '0;
  logic [4:0]     wr_func = '0;
  logic [7:0]     wr_data = '0;
  logic [7:0]     view_trig;
  logic           logic_trig;
  logic           pulse;

  logic [NCH-1:0] mask_m = '0;
  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  layer_coinc_trigger dut (
    .clk(clk), .rst(rst), .hits_i(hits), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_func_i(wr_func), .wr_data_i(wr_data), .view_trig_o(view_trig),
    .logic_trig_o(logic_trig), .pulse_o(pulse)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic int ch(int v, int f, int layer);
    return 56*v + 14*f + (layer - 1);
  endfunction

  function automatic logic [7:0] exp_views(logic [NCH-1:0] h, logic [NCH-1:0] m);
    logic [7:0] r = '0;
    for (int v = 0; v < 2; v++)
      for (int f = 0; f < NF; f++) begin
        int w = 5 - f;
        for (int s = 1; s + w - 1 <= NL; s++) begin
          bit ok = 1'b1;
          for (int k = 0; k < w; k++)
            if (!(h[ch(v, f, s+k)] && !m[ch(v, f, s+k)])) ok = 1'b0;
          if (ok) r[4*v+f] = 1'b1;
        end
      end
    return r;
  endfunction

  function automatic logic [NCH-1:0] run(int v, int f, int first, int last);
    logic [NCH-1:0] r = '0;
    for (int l = first; l <= last; l++) r[ch(v, f, l)] = 1'b1;
    return r;
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [4:0] fn, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_func = fn; wr_data = d;
    if (fn == 5'd17 && a < 4'd14)
      for (int b = 0; b < 8; b++) mask_m[8*a+b] = d[b];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    @(negedge clk);
    hits = '0;
    repeat (n) @(negedge clk);
  endtask

  task automatic view_case(logic [NCH-1:0] h, string tag);
    logic [7:0] e;
    @(negedge clk);
    hits = h;
    e = exp_views(h, mask_m);
    repeat (3) @(negedge clk);
    check(view_trig === e, {tag, " R9 views"}, view_trig, e);
    @(negedge clk);
    check(logic_trig === (|e), {tag, " R3 trig"}, logic_trig, |e);
  endtask

  task automatic pulse_case(logic [15:0] on, int exp_len, string tag);
    logic [NCH-1:0] p = run(0, 3, 1, 2);
    int n = 0;
    int first = -1;
    @(negedge clk);
    hits = on[0] ? p : '0;
    for (int c = 1; c < 80; c++) begin
      @(negedge clk);
      if (pulse) begin
        n++;
        if (first < 0) first = c;
      end
      hits = (c < 16 && on[c]) ? p : '0;
    end
    check(first == 4, {tag, " R9 pulse start"}, first, 4);
    check(n == exp_len, {tag, " width"}, n, exp_len);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(view_trig === 8'h00 && logic_trig === 1'b0 && pulse === 1'b0,
          "R6 reset outputs", {view_trig, logic_trig, pulse}, 0);

    view_case(run(0, 0, 1, 5), "R1 x f1 five");
    view_case(run(0, 0, 1, 4), "R1 x f1 four");
    view_case(run(0, 3, 13, 14), "R1 x f4 edge");
    view_case(run(0, 1, 11, 13), "R1 x f2 three");
    view_case(run(1, 2, 12, 14), "R2 y f3 only");
    view_case(run(1, 0, 10, 14) | run(0, 2, 1, 2), "R2 mixed");
    check(exp_views(run(1, 2, 12, 14), '0) == 8'h40, "R2 bench encoding", 0, 0);

    wr(4'd0, 5'd17, 8'h04);
    view_case(run(0, 0, 1, 7), "R4 masked layer3 blocks");
    view_case(run(0, 0, 1, 8), "R4 window past mask");
    wr(4'd0, 5'd17, 8'h00);

    wr(4'd1, 5'd17, 8'h40);
    view_case(run(0, 1, 1, 4), "R5 word1 bit6 x f2 l1");
    view_case(run(0, 1, 2, 5), "R5 unmasked window");
    wr(4'd7, 5'd17, 8'h01);
    view_case(run(1, 0, 1, 5), "R5 word7 bit0 y f1 l1");

    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd1; wr_func = 5'd16; wr_data = 8'h00;
    @(negedge clk);
    wr_en = 1'b0;
    view_case(run(0, 1, 1, 4), "R7 foreign func ignored");
    wr(4'd14, 5'd17, 8'hFF);
    view_case(run(0, 1, 2, 5), "R7 addr14 no effect");
    wr(4'd1, 5'd17, 8'h00);
    wr(4'd7, 5'd17, 8'h00);
    view_case(run(0, 1, 1, 4), "R7 real write clears");
    idle(60);

    pulse_case(16'h0003, 6, "R8 code0");
    wr(4'd15, 5'd17, 8'h01);
    pulse_case(16'h0003, 6, "R8 code1");
    wr(4'd15, 5'd17, 8'h03);
    pulse_case(16'h0003, 18, "R8 code3");
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd15; wr_func = 5'd9; wr_data = 8'h07;
    @(negedge clk);
    wr_en = 1'b0;
    pulse_case(16'h0003, 18, "R7 width kept");
    wr(4'd15, 5'd17, 8'hF8 | 8'h07);
    pulse_case(16'h0003, 42, "R8 code7");
    pulse_case(16'h0033, 46, "R10 retrigger reload");
    wr(4'd15, 5'd17, 8'h01);
    pulse_case(16'hFFFF, 6, "R10 held no restart");

    for (int it = 0; it < 60; it++) begin
      logic [NCH-1:0] h;
      int dens = (it % 3 == 0) ? 4 : ((it % 3 == 1) ? 15 : 35);
      if (it % 10 == 5)
        for (int k = 0; k < 14; k++) wr(4'(k), 5'd17, 8'($urandom & $urandom & $urandom));
      for (int b = 0; b < NCH; b++) h[b] = (($urandom % 100) < dens);
      view_case(h, "R1 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule